// File: doc/BRIEF.md
# Parallel Fully Connected MAC Engine

This block computes one output neuron of a fully connected layer per run. A controller pulses a start request together with a row count. A small sequencer then walks that many rows. On each cycle it reads one row of input activations and one row of weights from two synchronous memories that answer one clock after the address. Every row carries seven unsigned 8-bit values. Lane k multiplies activation element k by weight element k and keeps a running total. The multiply and the add sit in separate pipeline stages, so the path through each lane stays short.

When the last product has reached its total, the sequencer signals completion for one cycle. A result stage adds up the seven lane totals, keeps the bits above a fixed shift, saturates them to 8 bits and presents the value. Results are collected four to a 32-bit word, and each full word is written to an output memory at consecutive addresses. The weight address keeps running from one run to the next, so successive runs walk through successive weight rows while the same activation rows are read again from address 0.

Top module: `fc_mac_engine`

## Requirements
- R1: While reset is held and just after it is released, busy_o, done_o, act_rd_o, wgt_rd_o, result_valid_o and res_wr_o are all 0.
- R2: run_i seen high while idle starts a run. From the next cycle on, exactly N = run_count_i reads are issued on consecutive cycles, with act_addr_o counting 0 up to N-1 and act_rd_o and wgt_rd_o high together.
- R3: wgt_addr_o starts at 0 after reset and advances by one on every read. It is never rewound between runs, so run j starts where run j-1 stopped, modulo 2^WAW.
- R4: Lane k takes bits [8k+7:8k] of both rows. The run total is the unsigned sum, over all rows read and all seven lanes, of activation times weight.
- R5: All lane totals are cleared when a run starts, so each result depends only on the rows of its own run.
- R6: done_o is high for exactly one cycle, N+2 cycles after the first run cycle (the cycle after run_i was taken). busy_o is high from the first run cycle through the done cycle, and low on the cycle after.
- R7: In the cycle after done_o, result_valid_o is high for one cycle and result_o = min(255, total >> 8).
- R8: Result number r (counted from 0 after reset) goes into byte r mod 4 of a word, at bits [8j+7:8j] for j = r mod 4. When byte 3 is filled, res_wr_o pulses in the same cycle as result_valid_o, with res_word_o holding the four bytes and res_addr_o = r div 4.
- R9: run_i and run_count_i are ignored while busy_o is high. The count is captured only at the start of a run.
- R10: A run with N = 0 issues no reads, gives result 0, and raises done_o two cycles after the first run cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_i | input | 1 | Start request, taken while idle |
| run_count_i | input | CNT_W | Number of rows for the run |
| busy_o | output | 1 | Run in progress, including the done cycle |
| done_o | output | 1 | One-cycle end-of-run marker |
| act_rd_o | output | 1 | Activation memory read enable |
| act_addr_o | output | AW | Activation row address |
| act_row_i | input | LANES*DW | Activation row, one cycle after the address |
| wgt_rd_o | output | 1 | Weight memory read enable |
| wgt_addr_o | output | WAW | Weight row address |
| wgt_row_i | input | LANES*DW | Weight row, one cycle after the address |
| result_valid_o | output | 1 | result_o is fresh this cycle |
| result_o | output | 8 | Scaled and saturated neuron value |
| res_wr_o | output | 1 | Output memory write strobe |
| res_addr_o | output | RAW | Output memory word address |
| res_word_o | output | PACK*8 | Four packed results |

## Verification
The bench targets the pipeline drain. If done_o were raised before the last product reached its total, the final row would drop out of the result, and runs of one row and of zero rows would show it at once. Weight addresses that were rewound between runs would produce results that repeat the first run's weights. Missing clears would carry totals over from one run to the next. A long run with full-range operands drives the scaled value well past 255: a design that wraps instead of saturating shows small values there. The packing check runs across twelve results, so a byte placed in the wrong slot, a write in the wrong cycle or an address that fails to advance all show up in the written words.

// File: rtl/fc_mac_pkg.sv
package fc_mac_pkg;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RUN  = 2'd1,
    MV_DONE = 2'd2
  } mv_state_e;

  // Drop the low fraction bits of a total and clamp to the 8-bit range.
  function automatic logic [7:0] scale_sat(input logic [63:0] total, input int unsigned shift);
    logic [63:0] scaled;
    scaled = total >> shift;
    if (scaled > 64'd255) return 8'hFF;
    return scaled[7:0];
  endfunction

endpackage

// File: rtl/fc_row_mover.sv
module fc_row_mover
  import fc_mac_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int AW    = 8,
  parameter int WAW   = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] run_count_i,
  output logic             rd_o,
  output logic [AW-1:0]    act_addr_o,
  output logic [WAW-1:0]   wgt_addr_o,
  output logic             start_o,
  output logic             clear_o,
  output logic             done_o,
  output logic             busy_o
);

  localparam int CYC_W = CNT_W + 1;

  mv_state_e        state_q, state_d;
  logic [CYC_W-1:0] cyc_q;
  logic [CNT_W-1:0] rows_q;
  logic [WAW-1:0]   wptr_q;
  logic             last_cycle;

  assign start_o    = (state_q == MV_IDLE) && run_i;
  assign clear_o    = start_o;
  assign rd_o       = (state_q == MV_RUN) && (cyc_q < {1'b0, rows_q});
  // the last read plus two pipeline stages must have landed before DONE
  assign last_cycle = (state_q == MV_RUN) && (cyc_q == ({1'b0, rows_q} + 1'b1));
  assign act_addr_o = cyc_q[AW-1:0];
  assign wgt_addr_o = wptr_q;
  assign done_o     = (state_q == MV_DONE);
  assign busy_o     = (state_q != MV_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      MV_IDLE: if (run_i) state_d = MV_RUN;
      MV_RUN:  if (last_cycle) state_d = MV_DONE;
      MV_DONE: state_d = MV_IDLE;
      default: state_d = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= MV_IDLE;
      cyc_q   <= '0;
      rows_q  <= '0;
      wptr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (start_o) begin
        rows_q <= run_count_i;
        cyc_q  <= '0;
      end else if (state_q == MV_RUN) begin
        cyc_q <= cyc_q + 1'b1;
      end
      if (rd_o) wptr_q <= wptr_q + 1'b1;
    end
  end

endmodule

// File: rtl/fc_mac_lane.sv
module fc_mac_lane #(
  parameter int DW    = 8,
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             vld_i,
  input  logic [DW-1:0]    a_i,
  input  logic [DW-1:0]    b_i,
  output logic [ACC_W-1:0] acc_o
);

  localparam int PW = 2 * DW;

  function automatic logic [PW-1:0] umul(input logic [DW-1:0] x, input logic [DW-1:0] y);
    return PW'(x) * PW'(y);
  endfunction

  logic [PW-1:0]    prod_q;
  logic             prod_vld_q;
  logic [ACC_W-1:0] acc_q;

  // stage 1: product register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod_q     <= '0;
      prod_vld_q <= 1'b0;
    end else begin
      prod_q     <= umul(a_i, b_i);
      prod_vld_q <= vld_i && !clear_i;
    end
  end

  // stage 2: accumulate
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (clear_i) begin
      acc_q <= '0;
    end else if (prod_vld_q) begin
      acc_q <= acc_q + ACC_W'(prod_q);
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/fc_result_packer.sv
module fc_result_packer
  import fc_mac_pkg::*;
#(
  parameter int LANES = 7,
  parameter int ACC_W = 24,
  parameter int SHIFT = 8,
  parameter int PACK  = 4,
  parameter int RAW   = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   done_i,
  input  logic [LANES*ACC_W-1:0] acc_i,
  output logic                   result_vld_o,
  output logic [7:0]             result_o,
  output logic                   wr_o,
  output logic [RAW-1:0]         wr_addr_o,
  output logic [PACK*8-1:0]      wr_data_o
);

  localparam int SUM_W  = ACC_W + $clog2(LANES + 1);
  localparam int SLOT_W = (PACK > 1) ? $clog2(PACK) : 1;
  localparam int LAST   = PACK - 1;

  logic [SUM_W-1:0]  sum;
  logic [7:0]        res8;
  logic [SLOT_W-1:0] slot_q;
  logic [PACK*8-1:0] word_q, word_d;
  logic [RAW-1:0]    addr_q;
  logic              word_full;

  always_comb begin
    sum = '0;
    for (int k = 0; k < LANES; k++) sum = sum + SUM_W'(acc_i[k*ACC_W +: ACC_W]);
  end

  assign res8      = scale_sat(64'(sum), SHIFT);
  assign word_full = (slot_q == SLOT_W'(LAST));

  always_comb begin
    word_d = word_q;
    word_d[slot_q*8 +: 8] = res8;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q       <= '0;
      word_q       <= '0;
      addr_q       <= '0;
      result_vld_o <= 1'b0;
      result_o     <= '0;
      wr_o         <= 1'b0;
      wr_addr_o    <= '0;
      wr_data_o    <= '0;
    end else begin
      result_vld_o <= 1'b0;
      wr_o         <= 1'b0;
      if (done_i) begin
        result_vld_o <= 1'b1;
        result_o     <= res8;
        word_q       <= word_d;
        if (word_full) begin
          wr_o      <= 1'b1;
          wr_data_o <= word_d;
          wr_addr_o <= addr_q;
          addr_q    <= addr_q + 1'b1;
          slot_q    <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fc_mac_engine.sv
module fc_mac_engine #(
  parameter int LANES = 7,
  parameter int DW    = 8,
  parameter int CNT_W = 8,
  parameter int AW    = 8,
  parameter int WAW   = 10,
  parameter int RAW   = 8,
  parameter int SHIFT = 8,
  parameter int PACK  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run_i,
  input  logic [CNT_W-1:0]    run_count_i,
  output logic                busy_o,
  output logic                done_o,
  output logic                act_rd_o,
  output logic [AW-1:0]       act_addr_o,
  input  logic [LANES*DW-1:0] act_row_i,
  output logic                wgt_rd_o,
  output logic [WAW-1:0]      wgt_addr_o,
  input  logic [LANES*DW-1:0] wgt_row_i,
  output logic                result_valid_o,
  output logic [7:0]          result_o,
  output logic                res_wr_o,
  output logic [RAW-1:0]      res_addr_o,
  output logic [PACK*8-1:0]   res_word_o
);

  localparam int ACC_W = 2 * DW + CNT_W;

  // named internal events, observed by the bound checker
  logic                   run_start;
  logic                   lane_clear;
  logic                   row_read;
  logic                   row_arrived;
  logic                   run_done;
  logic [LANES*ACC_W-1:0] lane_totals;

  fc_row_mover #(
    .CNT_W (CNT_W),
    .AW    (AW),
    .WAW   (WAW)
  ) u_mover (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_i       (run_i),
    .run_count_i (run_count_i),
    .rd_o        (row_read),
    .act_addr_o  (act_addr_o),
    .wgt_addr_o  (wgt_addr_o),
    .start_o     (run_start),
    .clear_o     (lane_clear),
    .done_o      (run_done),
    .busy_o      (busy_o)
  );

  assign act_rd_o = row_read;
  assign wgt_rd_o = row_read;
  assign done_o   = run_done;

  // memories answer one clock after the address
  always_ff @(posedge clk) begin
    if (!rst_n) row_arrived <= 1'b0;
    else        row_arrived <= row_read;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fc_mac_lane #(
      .DW    (DW),
      .ACC_W (ACC_W)
    ) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (lane_clear),
      .vld_i   (row_arrived),
      .a_i     (act_row_i[k*DW +: DW]),
      .b_i     (wgt_row_i[k*DW +: DW]),
      .acc_o   (lane_totals[k*ACC_W +: ACC_W])
    );
  end

  fc_result_packer #(
    .LANES (LANES),
    .ACC_W (ACC_W),
    .SHIFT (SHIFT),
    .PACK  (PACK),
    .RAW   (RAW)
  ) u_packer (
    .clk          (clk),
    .rst_n        (rst_n),
    .done_i       (run_done),
    .acc_i        (lane_totals),
    .result_vld_o (result_valid_o),
    .result_o     (result_o),
    .wr_o         (res_wr_o),
    .wr_addr_o    (res_addr_o),
    .wr_data_o    (res_word_o)
  );

endmodule

// File: rtl/fc_mac_engine_chk.sv
module fc_mac_engine_chk #(
  parameter int AW  = 8,
  parameter int WAW = 10
) (
  input logic           clk,
  input logic           rst_n,
  input logic           run_i,
  input logic           busy_o,
  input logic           done_o,
  input logic           act_rd_o,
  input logic [AW-1:0]  act_addr_o,
  input logic           wgt_rd_o,
  input logic [WAW-1:0] wgt_addr_o,
  input logic           result_valid_o,
  input logic           res_wr_o,
  input logic           lane_clear
);

  a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);

  a_r2_read_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    act_rd_o |-> (busy_o && !done_o && wgt_rd_o));

  a_r2_act_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act_rd_o && $past(act_rd_o)) |-> (act_addr_o == $past(act_addr_o) + 1'b1));

  a_r3_wgt_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wgt_rd_o) |-> (wgt_addr_o == $past(wgt_addr_o) + 1'b1));

  a_r9_start_from_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(run_i));

  a_r5_clear_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(lane_clear));

  a_r7_valid_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid_o |-> $past(done_o));

  a_r8_write_with_result: assert property (@(posedge clk) disable iff (!rst_n)
    res_wr_o |-> result_valid_o);

endmodule

bind fc_mac_engine fc_mac_engine_chk #(
  .AW  (AW),
  .WAW (WAW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .run_i          (run_i),
  .busy_o         (busy_o),
  .done_o         (done_o),
  .act_rd_o       (act_rd_o),
  .act_addr_o     (act_addr_o),
  .wgt_rd_o       (wgt_rd_o),
  .wgt_addr_o     (wgt_addr_o),
  .result_valid_o (result_valid_o),
  .res_wr_o       (res_wr_o),
  .lane_clear     (lane_clear)
);

// File: tb/fc_mac_engine_bench.sv
`timescale 1ns/1ps
module fc_mac_engine_bench;

  localparam int LANES = 7;
  localparam int DW    = 8;
  localparam int CNT_W = 8;
  localparam int AW    = 8;
  localparam int WAW   = 10;
  localparam int RAW   = 8;
  localparam int ROW_W = LANES * DW;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             run_i = 1'b0;
  logic [CNT_W-1:0] run_count_i = '0;
  logic             busy_o, done_o, act_rd_o, wgt_rd_o;
  logic [AW-1:0]    act_addr_o;
  logic [WAW-1:0]   wgt_addr_o;
  logic [ROW_W-1:0] act_row_i, wgt_row_i;
  logic             result_valid_o, res_wr_o;
  logic [7:0]       result_o;
  logic [RAW-1:0]   res_addr_o;
  logic [31:0]      res_word_o;

  always #4 clk = ~clk;

  fc_mac_engine u_fc_mac_engine (
    .clk(clk), .rst_n(rst_n), .run_i(run_i), .run_count_i(run_count_i),
    .busy_o(busy_o), .done_o(done_o),
    .act_rd_o(act_rd_o), .act_addr_o(act_addr_o), .act_row_i(act_row_i),
    .wgt_rd_o(wgt_rd_o), .wgt_addr_o(wgt_addr_o), .wgt_row_i(wgt_row_i),
    .result_valid_o(result_valid_o), .result_o(result_o),
    .res_wr_o(res_wr_o), .res_addr_o(res_addr_o), .res_word_o(res_word_o)
  );

  // operand values: low activation rows are small so short runs stay unsaturated
  function automatic int act_val(int r, int k);
    if (r < 4) return (r * 3 + k) % 4;
    return (r * 37 + k * 11 + 5) % 256;
  endfunction
  function automatic int wgt_val(int a, int k);
    return (a * 29 + k * 53 + 7) % 256;
  endfunction

  logic [ROW_W-1:0] act_mem [256];
  logic [ROW_W-1:0] wgt_mem [1024];

  initial begin
    for (int r = 0; r < 256; r++)
      for (int k = 0; k < LANES; k++) act_mem[r][k*8 +: 8] = 8'(act_val(r, k));
    for (int a = 0; a < 1024; a++)
      for (int k = 0; k < LANES; k++) wgt_mem[a][k*8 +: 8] = 8'(wgt_val(a, k));
  end

  always @(posedge clk) begin
    if (act_rd_o) act_row_i <= act_mem[act_addr_o];
    if (wgt_rd_o) wgt_row_i <= wgt_mem[wgt_addr_o];
  end

  int n_chk = 0;
  int n_fail = 0;
  bit checking = 0;
  bit finished = 0;

  task automatic chk(input string tag, input longint actual, input longint expected);
    n_chk++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // behavioural reference, advanced once per rising edge
  int m_phase = -1;
  int m_n = 0;
  int m_wptr = 0;
  int m_wbase = 0;
  longint m_total = 0;
  bit m_rvalid = 0;
  int m_result = 0;
  bit m_wr = 0;
  int m_slot = 0;
  int m_waddr = 0;
  int m_wr_addr = 0;
  bit [31:0] m_word = 0;
  bit [31:0] m_wr_word = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = -1; m_wptr = 0; m_slot = 0; m_waddr = 0; m_word = 0;
      m_rvalid = 0; m_wr = 0;
    end else begin
      m_rvalid = 0;
      m_wr = 0;
      if (m_phase < 0) begin
        if (run_i) begin
          m_phase = 0;
          m_n = int'(run_count_i);
          m_wbase = m_wptr;
          m_total = 0;
          for (int i = 0; i < m_n; i++)
            for (int k = 0; k < LANES; k++)
              m_total += longint'(act_val(i, k) * wgt_val((m_wbase + i) % 1024, k));
          m_wptr = (m_wptr + m_n) % 1024;
        end
      end else if (m_phase == m_n + 2) begin
        m_phase = -1;
        m_result = ((m_total >> 8) > 255) ? 255 : int'(m_total >> 8);
        m_rvalid = 1;
        m_word[m_slot*8 +: 8] = 8'(m_result);
        if (m_slot == 3) begin
          m_wr = 1;
          m_wr_word = m_word;
          m_wr_addr = m_waddr;
          m_waddr++;
          m_slot = 0;
        end else begin
          m_slot++;
        end
      end else begin
        m_phase++;
      end
    end
  end

  always @(negedge clk) begin
    if (checking && !finished) begin
      chk("R6 busy_o", busy_o, m_phase >= 0);
      chk("R6 done_o", done_o, m_phase >= 0 && m_phase == m_n + 2);
      chk("R2 act_rd_o", act_rd_o, m_phase >= 0 && m_phase < m_n);
      chk("R2 wgt_rd_o", wgt_rd_o, m_phase >= 0 && m_phase < m_n);
      if (m_phase >= 0 && m_phase < m_n) begin
        chk("R2 act_addr_o", act_addr_o, m_phase);
        chk("R3 wgt_addr_o", wgt_addr_o, (m_wbase + m_phase) % 1024);
      end
      chk("R7 result_valid_o", result_valid_o, m_rvalid);
      if (m_rvalid) chk("R4 R5 R7 R10 result_o", result_o, m_result);
      chk("R8 res_wr_o", res_wr_o, m_wr);
      if (m_wr) begin
        chk("R8 res_addr_o", res_addr_o, m_wr_addr);
        chk("R8 res_word_o", res_word_o, m_wr_word);
      end
    end
  end

  // R9: run_i held and run_count_i changed while busy must be ignored
  task automatic do_run(input int n, input int hold);
    run_i = 1'b1;
    run_count_i = CNT_W'(n);
    repeat (hold) @(negedge clk);
    run_i = 1'b0;
    run_count_i = 8'hAA;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: quiet outputs under reset
    chk("R1 busy_o", busy_o, 0);
    chk("R1 done_o", done_o, 0);
    chk("R1 act_rd_o", act_rd_o, 0);
    chk("R1 result_valid_o", result_valid_o, 0);
    chk("R1 res_wr_o", res_wr_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    checking = 1;
    do_run(3, 1);
    do_run(1, 1);
    do_run(0, 1);   // R10
    do_run(4, 1);   // first packed word (R8)
    do_run(2, 4);   // R9 request held through the run
    do_run(20, 1);  // saturation (R7)
    do_run(6, 1);
    do_run(2, 1);   // second packed word
    do_run(1, 1);
    do_run(0, 1);
    do_run(5, 1);
    do_run(3, 1);   // third packed word
    repeat (4) @(negedge clk);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    summary();
  end

endmodule